// File: doc/BRIEF.md
# Saturating single-precision result packer

This block sits at the tail of a floating-point datapath. It accepts an intermediate result as a sign, an unbiased exponent with extra headroom, and a normalised significand with the leading one present. It emits a 32-bit single-precision word one clock cycle later. The encoding is not IEEE: the top exponent code is an ordinary finite binade, so there is no infinity and no NaN. Results too large for it saturate to the largest magnitude, and results too small for the lowest binade flush to zero. No denormals are produced, and the significand is cut off with no rounding.

Each operation carries a flag-enable bit. When that bit is set, an overflow or underflow event sets a sticky bit in an 8-bit status output. The bits stay set until a status write with a one in the matching position clears them. An event in the same cycle as the clear wins, so the bit stays set.

Top module: `fpk_top`

## Requirements
- R1: When `in_valid` is high with a nonzero significand and a biased exponent (`in_exp` + 127) in 1..254, the next cycle shows `out_valid` high and `out_word` = {`in_sign`, biased exponent in bits 30:23, `in_sig[22:0]` in bits 22:0}. `out_valid` is low in any cycle that follows a cycle with `in_valid` low.
- R2: A biased exponent of exactly 255 (`in_exp` = 128) is packed as a finite number with exponent field 0xFF and the truncated fraction. It raises no overflow flag.
- R3: A biased exponent above 255 produces `out_word` = {`in_sign`, 0xFF, 0x7FFFFF}.
- R4: A nonzero result with a biased exponent below 1 (`in_exp` < -126) produces `out_word` = {`in_sign`, 31 zero bits}. A biased exponent of exactly 1 is still packed as a normal number.
- R5: A zero significand produces {`in_sign`, 31 zero bits} and never sets a flag, whatever its exponent.
- R6: An R3 overflow accepted with `flag_en` high sets `status[4]` in the next cycle. The bit then stays set.
- R7: An R4 underflow accepted with `flag_en` high sets `status[3]` in the next cycle. The bit then stays set.
- R8: With `flag_en` low, overflow and underflow results are still clamped or flushed, but `status` does not change.
- R9: A cycle with `wr_en` high clears `status[4]` and/or `status[3]` where `wr_data` has a one in that position. A flag event in the same cycle leaves the bit set. All other status bits always read 0.
- R10: After reset, `out_valid` is 0, `out_word` is 0 and `status` is 0.
- R11: The fraction is truncated and never rounded. A significand of all ones keeps its exponent and yields a fraction of 0x7FFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | An intermediate result is presented this cycle |
| in_sign | input | 1 | Result sign |
| in_exp | input | 10 | Unbiased exponent, two's complement |
| in_sig | input | 24 | Significand, bit 23 is the leading one; zero means an exact zero |
| flag_en | input | 1 | Allow this operation to set the sticky flags |
| wr_en | input | 1 | Status clear write strobe |
| wr_data | input | 8 | Write-one-to-clear mask for the status bits |
| out_valid | output | 1 | `out_word` holds a new result |
| out_word | output | 32 | Packed single-precision result |
| status | output | 8 | Sticky flags: bit 4 overflow, bit 3 underflow |

## Verification
The bench works the exponent edges from both sides. Exponent codes 254 and 255 must pack normally, and code 256 must clamp: a design that treated 255 as infinity would lose the fraction or raise the overflow flag there. On the low side, code 1 must survive and code 0 must flush with its sign. An off-by-one comparator would flush the smallest normal or pass through a zero exponent field. The bench also probes an exact zero with a large exponent, a significand of all ones, flag-disabled overflows, and a clear that collides with a new event. A design that let the clear win there would drop a sticky flag.

// File: rtl/fpk_pkg.sv
package fpk_pkg;
  // Classification of an intermediate result against the output range
  typedef enum logic [1:0] {
    CLS_NORM = 2'd0,
    CLS_OVF  = 2'd1,
    CLS_UNF  = 2'd2,
    CLS_ZERO = 2'd3
  } fpk_cls_e;
endpackage

// File: rtl/fpk_classify.sv
module fpk_classify #(
  parameter int EXP_W  = 10,
  parameter int SIG_W  = 24,
  parameter int EF_W   = 8,
  parameter int BIAS   = 127
) (
  input  logic signed [EXP_W-1:0] exp_i,
  input  logic [SIG_W-1:0]        sig_i,
  output fpk_pkg::fpk_cls_e       cls_o,
  output logic [EF_W-1:0]         efield_o
);
  localparam int BW = EXP_W + 2;
  localparam int EF_MAX = (1 << EF_W) - 1;
  localparam logic signed [BW-1:0] BIAS_B = BW'(BIAS);
  localparam logic signed [BW-1:0] TOP_B  = BW'(EF_MAX);
  localparam logic signed [BW-1:0] ONE_B  = BW'(1);

  logic signed [BW-1:0] biased;

  always_comb begin
    biased   = {{2{exp_i[EXP_W-1]}}, exp_i} + BIAS_B;
    efield_o = biased[EF_W-1:0];
    if (sig_i == '0)          cls_o = fpk_pkg::CLS_ZERO;
    else if (biased > TOP_B)  cls_o = fpk_pkg::CLS_OVF;
    else if (biased < ONE_B)  cls_o = fpk_pkg::CLS_UNF;
    else                      cls_o = fpk_pkg::CLS_NORM;
  end
endmodule

// File: rtl/fpk_encode.sv
module fpk_encode #(
  parameter int SIG_W = 24,
  parameter int EF_W  = 8,
  localparam int FRAC_W = SIG_W - 1,
  localparam int WORD_W = 1 + EF_W + FRAC_W
) (
  input  logic                sign_i,
  input  fpk_pkg::fpk_cls_e   cls_i,
  input  logic [EF_W-1:0]     efield_i,
  input  logic [SIG_W-1:0]    sig_i,
  output logic [WORD_W-1:0]   word_o
);
  always_comb begin
    case (cls_i)
      fpk_pkg::CLS_NORM: word_o = {sign_i, efield_i, sig_i[FRAC_W-1:0]};
      fpk_pkg::CLS_OVF:  word_o = {sign_i, {EF_W{1'b1}}, {FRAC_W{1'b1}}};
      default:           word_o = {sign_i, {(WORD_W-1){1'b0}}};
    endcase
  end
endmodule

// File: rtl/fpk_flags.sv
module fpk_flags #(
  parameter int STAT_W  = 8,
  parameter int OVF_BIT = 4,
  parameter int UNF_BIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ovf_ev,
  input  logic              unf_ev,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  output logic [STAT_W-1:0] status
);
  logic ovf_q, unf_q, ovf_d, unf_d, clr_ovf, clr_unf;

  always_comb begin
    clr_ovf = wr_en & wr_data[OVF_BIT];
    clr_unf = wr_en & wr_data[UNF_BIT];
    ovf_d   = ovf_ev | (ovf_q & ~clr_ovf);
    unf_d   = unf_ev | (unf_q & ~clr_unf);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  always_comb begin
    status          = '0;
    status[OVF_BIT] = ovf_q;
    status[UNF_BIT] = unf_q;
  end

  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[OVF_BIT] && !(wr_en && wr_data[OVF_BIT]) |=> status[OVF_BIT]);
  // R7
  unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[UNF_BIT] && !(wr_en && wr_data[UNF_BIT]) |=> status[UNF_BIT]);
  // R9
  clr_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_ev && wr_en && wr_data[OVF_BIT] |=> status[OVF_BIT]);
endmodule

// File: rtl/fpk_top.sv
module fpk_top #(
  parameter int EXP_W   = 10,
  parameter int SIG_W   = 24,
  parameter int EF_W    = 8,
  parameter int BIAS    = 127,
  parameter int STAT_W  = 8,
  parameter int OVF_BIT = 4,
  parameter int UNF_BIT = 3,
  localparam int WORD_W = EF_W + SIG_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    in_sign,
  input  logic signed [EXP_W-1:0] in_exp,
  input  logic [SIG_W-1:0]        in_sig,
  input  logic                    flag_en,
  input  logic                    wr_en,
  input  logic [STAT_W-1:0]       wr_data,
  output logic                    out_valid,
  output logic [WORD_W-1:0]       out_word,
  output logic [STAT_W-1:0]       status
);
  localparam int OVF_LIM = (1 << EF_W) - 1 - BIAS;
  localparam int UNF_LIM = 1 - BIAS;

  // reset synchroniser: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  fpk_pkg::fpk_cls_e    cls;
  logic [EF_W-1:0]      efield;
  logic [WORD_W-1:0]    word_c;
  logic                 ovf_ev, unf_ev;
  logic                 vld_d;
  logic [WORD_W-1:0]    word_d;

  fpk_classify #(.EXP_W(EXP_W), .SIG_W(SIG_W), .EF_W(EF_W), .BIAS(BIAS)) u_cls (
    .exp_i(in_exp), .sig_i(in_sig), .cls_o(cls), .efield_o(efield)
  );

  fpk_encode #(.SIG_W(SIG_W), .EF_W(EF_W)) u_enc (
    .sign_i(in_sign), .cls_i(cls), .efield_i(efield), .sig_i(in_sig), .word_o(word_c)
  );

  always_comb begin
    ovf_ev = in_valid & flag_en & (cls == fpk_pkg::CLS_OVF);
    unf_ev = in_valid & flag_en & (cls == fpk_pkg::CLS_UNF);
    vld_d  = in_valid;
    word_d = in_valid ? word_c : out_word;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= vld_d;
      out_word  <= word_d;
    end
  end

  fpk_flags #(.STAT_W(STAT_W), .OVF_BIT(OVF_BIT), .UNF_BIT(UNF_BIT)) u_flg (
    .clk(clk), .rst_n(rst_ni), .ovf_ev(ovf_ev), .unf_ev(unf_ev),
    .wr_en(wr_en), .wr_data(wr_data), .status(status)
  );

  // R1
  sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    in_valid |=> out_valid && out_word[WORD_W-1] == $past(in_sign));
  // R2
  top_binade_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    in_valid && in_sig[SIG_W-1] && int'(in_exp) == OVF_LIM |=> out_word[WORD_W-2 -: EF_W] == {EF_W{1'b1}});
  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    in_valid && in_sig[SIG_W-1] && int'(in_exp) > OVF_LIM |=> &out_word[WORD_W-2:0]);
  // R4
  flush_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    in_valid && int'(in_exp) < UNF_LIM |=> out_word[WORD_W-2:0] == '0);
  // R8
  flag_src_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(status[OVF_BIT]) |-> $past(in_valid && flag_en));
endmodule

// File: tb/tb_fpk_top.sv
module tb_fpk_top;
  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid, in_sign, flag_en, wr_en;
  logic signed [9:0] in_exp;
  logic [23:0]       in_sig;
  logic [7:0]        wr_data;
  logic              out_valid;
  logic [31:0]       out_word;
  logic [7:0]        status;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [31:0] q_word[$];
  string       q_tag[$];

  always #10 clk = ~clk;

  fpk_top dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
    .in_exp(in_exp), .in_sig(in_sig), .flag_en(flag_en), .wr_en(wr_en),
    .wr_data(wr_data), .out_valid(out_valid), .out_word(out_word), .status(status)
  );

  function automatic logic [31:0] model(input logic s, input int e, input logic [23:0] m);
    int b;
    b = e + 127;
    if (m == 24'd0)   return {s, 31'd0};
    if (b > 255)      return {s, 8'hFF, 23'h7FFFFF};
    if (b < 1)        return {s, 31'd0};
    return {s, b[7:0], m[22:0]};
  endfunction

  task automatic send(input logic s, input int e, input logic [23:0] m, input logic fe,
                      input logic we, input logic [7:0] wd, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_sign = s; in_exp = 10'(e); in_sig = m; flag_en = fe;
    wr_en = we; wr_data = wd;
    q_word.push_back(model(s, e, m));
    q_tag.push_back(tag);
    @(negedge clk);
    in_valid = 1'b0; wr_en = 1'b0; wr_data = 8'd0; flag_en = 1'b0;
  endtask

  task automatic clear(input logic [7:0] wd);
    @(negedge clk);
    wr_en = 1'b1; wr_data = wd;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'd0;
  endtask

  task automatic chk_stat(input logic [7:0] exp_s, input string tag);
    checks++;
    if (status !== exp_s) begin
      errors++;
      $display("FAIL %s status actual %02h expected %02h", tag, status, exp_s);
    end
  endtask

  // monitor: pops scoreboard on each result
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      checks++;
      if (q_word.size() == 0) begin
        errors++;
        $display("FAIL R1 unexpected result actual %08h expected none", out_word);
      end else begin
        logic [31:0] w;
        string t;
        w = q_word.pop_front();
        t = q_tag.pop_front();
        if (out_word !== w) begin
          errors++;
          $display("FAIL %s word actual %08h expected %08h", t, out_word, w);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_sign = 1'b0; in_exp = '0; in_sig = '0;
    flag_en = 1'b0; wr_en = 1'b0; wr_data = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state
    checks++;
    if (out_valid !== 1'b0 || out_word !== 32'd0) begin
      errors++;
      $display("FAIL R10 outputs actual %b/%08h expected 0/00000000", out_valid, out_word);
    end
    chk_stat(8'h00, "R10");

    send(1'b0, 0, 24'hC00000, 1'b1, 1'b0, 8'd0, "R1 plain");
    send(1'b1, -5, 24'hABCDEF, 1'b1, 1'b0, 8'd0, "R1 negative");
    send(1'b0, 127, 24'h9A5A5A, 1'b1, 1'b0, 8'd0, "R1 code 254");
    send(1'b0, 128, 24'h800001, 1'b1, 1'b0, 8'd0, "R2 code 255");
    chk_stat(8'h00, "R2 no flag");
    send(1'b1, -126, 24'h800000, 1'b1, 1'b0, 8'd0, "R4 smallest normal");
    chk_stat(8'h00, "R4 no flag");
    send(1'b0, 0, 24'hFFFFFF, 1'b1, 1'b0, 8'd0, "R11 truncate");

    // R3/R6 overflow just above the top binade
    send(1'b0, 129, 24'h800000, 1'b1, 1'b0, 8'd0, "R3 positive clamp");
    chk_stat(8'h10, "R6 set");
    send(1'b1, 300, 24'hF0F0F0, 1'b0, 1'b0, 8'd0, "R3 negative clamp");
    chk_stat(8'h10, "R6 sticky");

    // R4/R7 underflow just below smallest normal
    send(1'b1, -127, 24'hFFFFFF, 1'b1, 1'b0, 8'd0, "R4 flush");
    chk_stat(8'h18, "R7 set");

    // R9 clears
    clear(8'h10);
    chk_stat(8'h08, "R9 clear ovf");
    clear(8'hE7);
    chk_stat(8'h08, "R9 unrelated bits");
    clear(8'h08);
    chk_stat(8'h00, "R9 clear unf");

    // R5 zero never flags
    send(1'b1, -400, 24'd0, 1'b1, 1'b0, 8'd0, "R5 zero tiny exp");
    send(1'b0, 400, 24'd0, 1'b1, 1'b0, 8'd0, "R5 zero huge exp");
    chk_stat(8'h00, "R5 no flag");

    // R8 flag disabled
    send(1'b0, 200, 24'h812345, 1'b0, 1'b0, 8'd0, "R8 ovf clamp");
    send(1'b0, -200, 24'h812345, 1'b0, 1'b0, 8'd0, "R8 unf flush");
    chk_stat(8'h00, "R8 no flag");

    // R9 clear colliding with a new event
    send(1'b0, 130, 24'h800000, 1'b1, 1'b0, 8'd0, "R6 again");
    send(1'b1, 131, 24'hC00000, 1'b1, 1'b1, 8'h10, "R9 collide");
    chk_stat(8'h10, "R9 event wins");

    // R1 no result without valid
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 idle valid actual %b expected 0", out_valid);
    end
    checks++;
    if (q_word.size() != 0) begin
      errors++;
      $display("FAIL R1 missing results actual %0d expected 0", q_word.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule